// File: doc/BRIEF.md
# Fail-Safe Clock Start-Up Supervisor

This block decides when the processor may start running after system reset and keeps watching the chosen primary clock once it is running. The primary clock counts as usable only after its start-up timer has run out (crystal source) and the frequency synthesizer reports lock (PLL source). Until then the run enable stays low. Both waits run on their own schedule and are not tied to the chip's power-up reset delays.

A monitor runs in the domain of an always-running internal RC reference clock. Crystal and PLL sources get a settling window, counted in reference cycles from reset release, before monitoring starts. Other sources are monitored from reset release. The monitor watches a divided toggle taken from the primary clock. If the toggle shows no activity for a set number of reference cycles, the block moves the clock select to the internal RC clock, raises a one-cycle trap request and sets a sticky failure flag. Software clears the flag, which moves the select back to the primary clock and re-arms the monitor.

Top module: `clkfs_supervisor`

## Requirements
- R1: While `rst` is high and right after it, `cpu_run_en`, `clk_sel`, `trap` and `fail_flag` are 0. With `src_xtal`=1, `cpu_run_en` stays 0 until the primary clock has run `OST_CYC` cycles after reset release, then goes to 1.
- R2: With `src_pll`=1, `cpu_run_en` also waits for `pll_lock`=1 and goes to 1 a few reference cycles after lock arrives.
- R3: With `src_xtal`=0 and `src_pll`=0, `cpu_run_en` goes to 1 within two reference cycles of reset release.
- R4: With `src_xtal` or `src_pll` set, monitoring starts only after `SETTLE_CYC` reference cycles from reset release, so a missing primary clock raises no failure before that window ends.
- R5: With neither `src_xtal` nor `src_pll` set, monitoring starts at reset release, so a missing primary clock fails after about `TIMEOUT` reference cycles.
- R6: While monitoring, if the primary toggle shows no change for `TIMEOUT` reference cycles, `clk_sel` becomes 1 (0 = primary clock, 1 = internal RC clock), `fail_flag` becomes 1 and `trap` is high for exactly one cycle. `cpu_run_en` is 1 from then on. A primary clock that keeps running never causes a failure.
- R7: `fail_flag` stays 1 until `fail_clr` is pulsed, even if the primary clock comes back. The clear sets `clk_sel` to 0 and re-arms the monitor without a trap. `fail_clr` has no effect when no failure is recorded.
- R8: With `mon_en`=0 there is no switch and no trap, and start-up gating of `cpu_run_en` still applies.
- R9: `clk_sel` changes only together with a trap (to 1) or one cycle after a `fail_clr` (to 0), so it changes once per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running internal RC reference clock; clocks the supervisor |
| rst | input | 1 | Synchronous active-high system reset (reference domain) |
| pri_clk | input | 1 | Selected primary clock under supervision; may be absent |
| src_xtal | input | 1 | Primary source is a crystal oscillator (start-up timer applies) |
| src_pll | input | 1 | Primary source passes through the PLL (lock required) |
| pll_lock | input | 1 | Asynchronous PLL lock indication |
| mon_en | input | 1 | Enables failure monitoring |
| fail_clr | input | 1 | Software clear of the failure flag, one-cycle pulse |
| clk_sel | output | 1 | Clock select: 0 primary, 1 internal RC |
| cpu_run_en | output | 1 | Processor run enable; high once the selected clock is valid |
| trap | output | 1 | One-cycle clock-failure trap request |
| fail_flag | output | 1 | Sticky clock-failure status |

## Verification
On every cycle the assertions check that the trap is a single-cycle pulse and that it rises with the failure flag. They also check that the flag clears only after a clear request, that the clock select moves only with a trap or a clear, that no switch happens while monitoring is off, and that the settling window is not cut short for slow-starting sources. Only the bench scenarios can show the timing seen from outside. These cover the start-up timer and PLL-lock gating of the run enable, a missing clock that goes unflagged through the settling window but is flagged quickly for other sources, a clock that stops in mid-run, and a sticky flag that survives the clock returning.

// File: rtl/csup_pkg.sv
package csup_pkg;
  typedef enum logic [1:0] {
    MON_SETTLE  = 2'd0,
    MON_WATCH   = 2'd1,
    MON_TRIPPED = 2'd2
  } mon_state_t;

  typedef enum logic {
    SEL_PRIMARY = 1'b0,
    SEL_RC      = 1'b1
  } clk_src_t;
endpackage

// File: rtl/csup_sync.sv
module csup_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/csup_pri_dom.sv
module csup_pri_dom #(
  parameter int OST_CYC = 1024,
  parameter int PRI_DIV = 4
) (
  input  logic pri_clk,
  input  logic rst,
  output logic ost_done,
  output logic pri_tog
);
  localparam int OW = $clog2(OST_CYC + 1);
  localparam int DW = (PRI_DIV > 1) ? $clog2(PRI_DIV) : 1;

  // reset enters asynchronously (the primary clock may be absent), leaves on a primary edge
  logic [1:0] rsync;
  always_ff @(posedge pri_clk or posedge rst) begin
    if (rst) rsync <= 2'b11;
    else     rsync <= {rsync[0], 1'b0};
  end

  logic prst;
  assign prst = rsync[1];

  logic [OW-1:0] ost_cnt;
  always_ff @(posedge pri_clk or posedge prst) begin
    if (prst) begin
      ost_cnt  <= '0;
      ost_done <= 1'b0;
    end else if (!ost_done) begin
      if (ost_cnt == OW'(OST_CYC - 1)) ost_done <= 1'b1;
      ost_cnt <= ost_cnt + 1'b1;
    end
  end

  logic [DW-1:0] div_cnt;
  always_ff @(posedge pri_clk or posedge prst) begin
    if (prst) begin
      div_cnt <= '0;
      pri_tog <= 1'b0;
    end else if (div_cnt == DW'(PRI_DIV - 1)) begin
      div_cnt <= '0;
      pri_tog <= ~pri_tog;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/csup_gate.sv
module csup_gate (
  input  logic clk,
  input  logic rst,
  input  logic src_xtal,
  input  logic src_pll,
  input  logic ost_s,
  input  logic lock_s,
  input  logic rc_sel,
  output logic cpu_run_en
);
  logic pri_ok;
  assign pri_ok = (!src_xtal || ost_s) && (!src_pll || lock_s);

  always_ff @(posedge clk) begin
    if (rst) cpu_run_en <= 1'b0;
    else     cpu_run_en <= rc_sel || pri_ok;
  end
endmodule

// File: rtl/csup_monitor.sv
module csup_monitor
  import csup_pkg::*;
#(
  parameter int SETTLE_CYC = 3686,
  parameter int TIMEOUT    = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic src_slow,
  input  logic mon_en,
  input  logic tog_s,
  input  logic fail_clr,
  output logic clk_sel,
  output logic trap,
  output logic fail_flag
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int TW = $clog2(TIMEOUT + 1);

  mon_state_t    state;
  logic [SW-1:0] settle_cnt;
  logic [TW-1:0] to_cnt;
  logic          tog_d;
  logic          tog_edge;

  assign tog_edge = tog_s ^ tog_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= MON_SETTLE;
      settle_cnt <= '0;
      to_cnt     <= '0;
      tog_d      <= 1'b0;
      clk_sel    <= SEL_PRIMARY;
      trap       <= 1'b0;
      fail_flag  <= 1'b0;
    end else begin
      tog_d <= tog_s;
      trap  <= 1'b0;
      case (state)
        MON_SETTLE: begin
          if (!src_slow || settle_cnt == SW'(SETTLE_CYC - 1)) begin
            state  <= MON_WATCH;
            to_cnt <= '0;
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        MON_WATCH: begin
          if (!mon_en || tog_edge) begin
            to_cnt <= '0;
          end else if (to_cnt == TW'(TIMEOUT - 1)) begin
            state     <= MON_TRIPPED;
            clk_sel   <= SEL_RC;
            trap      <= 1'b1;
            fail_flag <= 1'b1;
            to_cnt    <= '0;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        MON_TRIPPED: begin
          if (fail_clr) begin
            state     <= MON_WATCH;
            clk_sel   <= SEL_PRIMARY;
            fail_flag <= 1'b0;
          end
        end
        default: state <= MON_SETTLE;
      endcase
    end
  end

  // R6: trap lasts one cycle
  assert_trap_single_R6: assert property (@(posedge clk) disable iff (rst)
    trap |=> !trap);

  // R6: flag and trap rise together
  assert_flag_with_trap_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_flag) |-> trap);

  // R7: flag drops only after a clear request
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(fail_flag) |-> $past(fail_clr));

  // R9: select moves only with a trap or after a clear
  assert_sel_events_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_sel) |-> (trap || $past(fail_clr)));

  // R8: no switch while monitoring is disabled
  assert_no_switch_off_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_sel) |-> $past(mon_en));

  // R4: settling window runs to its end for slow sources
  assert_settle_full_R4: assert property (@(posedge clk) disable iff (rst)
    (state == MON_WATCH && $past(state) == MON_SETTLE && $past(src_slow))
      |-> $past(settle_cnt) == SW'(SETTLE_CYC - 1));
endmodule

// File: rtl/clkfs_supervisor.sv
module clkfs_supervisor #(
  parameter int OST_CYC    = 1024,
  parameter int PRI_DIV    = 4,
  parameter int SETTLE_CYC = 3686,
  parameter int TIMEOUT    = 64,
  parameter int SYNC_STG   = 2
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic pri_clk,
  input  logic src_xtal,
  input  logic src_pll,
  input  logic pll_lock,
  input  logic mon_en,
  input  logic fail_clr,
  output logic clk_sel,
  output logic cpu_run_en,
  output logic trap,
  output logic fail_flag
);
  logic ost_done, pri_tog;
  logic ost_s, tog_s, lock_s;

  csup_pri_dom #(.OST_CYC(OST_CYC), .PRI_DIV(PRI_DIV)) u_pri (
    .pri_clk (pri_clk),
    .rst     (rst),
    .ost_done(ost_done),
    .pri_tog (pri_tog)
  );

  csup_sync #(.W(3), .STAGES(SYNC_STG)) u_sync (
    .clk(ref_clk),
    .rst(rst),
    .d  ({pll_lock, ost_done, pri_tog}),
    .q  ({lock_s, ost_s, tog_s})
  );

  csup_monitor #(.SETTLE_CYC(SETTLE_CYC), .TIMEOUT(TIMEOUT)) u_mon (
    .clk      (ref_clk),
    .rst      (rst),
    .src_slow (src_xtal || src_pll),
    .mon_en   (mon_en),
    .tog_s    (tog_s),
    .fail_clr (fail_clr),
    .clk_sel  (clk_sel),
    .trap     (trap),
    .fail_flag(fail_flag)
  );

  csup_gate u_gate (
    .clk       (ref_clk),
    .rst       (rst),
    .src_xtal  (src_xtal),
    .src_pll   (src_pll),
    .ost_s     (ost_s),
    .lock_s    (lock_s),
    .rc_sel    (clk_sel),
    .cpu_run_en(cpu_run_en)
  );
endmodule

// File: tb/test_clkfs_supervisor.sv
module test_clkfs_supervisor;
  logic ref_clk = 1'b0, pri_clk = 1'b0, pri_on = 1'b0;
  logic rst = 1'b1, src_xtal = 1'b0, src_pll = 1'b0, pll_lock = 1'b0;
  logic mon_en = 1'b0, fail_clr = 1'b0;
  logic clk_sel, cpu_run_en, trap, fail_flag;
  int checks = 0, failures = 0;
  int trap_cnt = 0, sel_chg = 0, wide_trap = 0;
  logic trap_q = 1'b0, sel_q = 1'b0;
  bit done = 1'b0;

  always #5 ref_clk = ~ref_clk;
  always #15 if (pri_on) pri_clk = ~pri_clk;

  clkfs_supervisor #(.OST_CYC(16), .PRI_DIV(2), .SETTLE_CYC(40), .TIMEOUT(12)) i_clkfs_supervisor (
    .ref_clk(ref_clk), .rst(rst), .pri_clk(pri_clk), .src_xtal(src_xtal),
    .src_pll(src_pll), .pll_lock(pll_lock), .mon_en(mon_en), .fail_clr(fail_clr),
    .clk_sel(clk_sel), .cpu_run_en(cpu_run_en), .trap(trap), .fail_flag(fail_flag)
  );

  always @(posedge ref_clk) begin
    if (rst) begin
      trap_cnt <= 0; sel_chg <= 0; wide_trap <= 0; trap_q <= 1'b0; sel_q <= 1'b0;
    end else begin
      trap_q <= trap; sel_q <= clk_sel;
      if (trap) trap_cnt <= trap_cnt + 1;
      if (trap && trap_q) wide_trap <= wide_trap + 1;
      if (clk_sel != sel_q) sel_chg <= sel_chg + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge ref_clk);
    #1;
  endtask

  task automatic do_reset(input logic x, input logic p, input logic m, input logic on);
    src_xtal = x; src_pll = p; mon_en = m; pri_on = on; pll_lock = 1'b0; fail_clr = 1'b0;
    rst = 1'b1;
    cyc(6);
    rst = 1'b0;
  endtask

  task automatic t_reset_state;
    src_xtal = 1'b1; mon_en = 1'b1; pri_on = 1'b1; rst = 1'b1;
    cyc(4);
    chk("R1 run_en in reset", cpu_run_en, 0);
    chk("R1 clk_sel in reset", clk_sel, 0);
    chk("R1 trap in reset", trap, 0);
    chk("R1 fail_flag in reset", fail_flag, 0);
  endtask

  task automatic t_xtal_start;
    do_reset(1'b1, 1'b0, 1'b1, 1'b1);
    cyc(30);
    chk("R1 run_en before start-up timer", cpu_run_en, 0);
    cyc(60);
    chk("R1 run_en after start-up timer", cpu_run_en, 1);
    cyc(60);
    chk("R6 running clock no failure", fail_flag, 0);
    chk("R6 running clock no trap", trap_cnt, 0);
    fail_clr = 1'b1; cyc(1); fail_clr = 1'b0; cyc(3);
    chk("R7 idle clear flag", fail_flag, 0);
    chk("R7 idle clear select", clk_sel, 0);
    chk("R7 idle clear no trap", trap_cnt, 0);
  endtask

  task automatic t_pll;
    do_reset(1'b1, 1'b1, 1'b1, 1'b1);
    cyc(120);
    chk("R2 run_en waits for lock", cpu_run_en, 0);
    pll_lock = 1'b1;
    cyc(5);
    chk("R2 run_en after lock", cpu_run_en, 1);
  endtask

  task automatic t_ec_start;
    do_reset(1'b0, 1'b0, 1'b1, 1'b1);
    cyc(2);
    chk("R3 run_en without timer", cpu_run_en, 1);
    cyc(60);
    chk("R3 ext clock no failure", fail_flag, 0);
  endtask

  task automatic t_xtal_missing;
    do_reset(1'b1, 1'b0, 1'b1, 1'b0);
    cyc(45);
    chk("R4 no failure inside settle window", fail_flag, 0);
    chk("R4 run_en still held", cpu_run_en, 0);
    cyc(25);
    chk("R6 failure after settle", fail_flag, 1);
    chk("R6 select internal RC", clk_sel, 1);
    chk("R6 single trap", trap_cnt, 1);
    chk("R6 trap width", wide_trap, 0);
    chk("R6 run_en on RC clock", cpu_run_en, 1);
  endtask

  task automatic t_ec_missing;
    do_reset(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(6);
    chk("R5 no failure before timeout", fail_flag, 0);
    cyc(19);
    chk("R5 immediate monitoring failure", fail_flag, 1);
    chk("R5 single trap", trap_cnt, 1);
  endtask

  task automatic t_mon_off;
    do_reset(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(150);
    chk("R8 no flag when disabled", fail_flag, 0);
    chk("R8 no switch when disabled", clk_sel, 0);
    chk("R8 no trap when disabled", trap_cnt, 0);
    chk("R8 gating still applies", cpu_run_en, 0);
  endtask

  task automatic t_stop_clear;
    do_reset(1'b1, 1'b0, 1'b1, 1'b1);
    cyc(150);
    chk("R6 healthy before stop", fail_flag, 0);
    pri_on = 1'b0;
    cyc(30);
    chk("R6 stop detected", fail_flag, 1);
    chk("R6 stop select RC", clk_sel, 1);
    chk("R6 stop single trap", trap_cnt, 1);
    pri_on = 1'b1;
    cyc(30);
    chk("R7 flag sticky with clock back", fail_flag, 1);
    chk("R7 select stays RC", clk_sel, 1);
    fail_clr = 1'b1; cyc(1); fail_clr = 1'b0; cyc(2);
    chk("R7 flag cleared", fail_flag, 0);
    chk("R7 select back to primary", clk_sel, 0);
    cyc(60);
    chk("R7 rearmed no new trap", trap_cnt, 1);
    chk("R9 select changed twice", sel_chg, 2);
    chk("R6 trap width", wide_trap, 0);
  endtask

  initial begin
    t_reset_state();
    t_xtal_start();
    t_pll();
    t_ec_start();
    t_xtal_missing();
    t_ec_missing();
    t_mon_off();
    t_stop_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge ref_clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule